// File: doc/BRIEF.md
# GPIO Port Configuration Controller

This block controls one general-purpose I/O port of sixteen pins through a small synchronous register bus. Software sets a direction mode, a pull selection, an output type and a drive-strength code for each pin. From these fields the controller derives the pad controls for every pin: output enable, output value, pull-up and pull-down requests, an input-buffer enable and a two-bit strength class.

An output data register holds the levels that the output drivers present. A write-only set/clear register changes individual output bits atomically, so software does not need a read-modify-write cycle. Pad levels pass through a two-flop synchronizer and appear in a read-only input register. That register is masked to zero on any pin whose input buffer is off.

After reset every pin is a floating input, except two debug pins. Those two come up in alternate mode, one with a pull-up and one with a pull-down.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Mode code 00 (input) gives oe=0, out=0 and ie=1. The pin's input-register bit (address 7) shows the pad level two clock edges after the pad changes, and not after one.
- R2: Mode code 01 with output type 0 (push-pull) gives oe=1 and out equal to the output data bit, for both 0 and 1. The input buffer stays enabled.
- R3: Mode code 01 with output type 1 (open-drain) gives out=0 and oe equal to the inverse of the output data bit. The input buffer stays enabled.
- R4: Mode code 11 (analog) gives oe, out, ie, pull-up and pull-down all 0, whatever the pull field holds. The pin's input-register bit reads 0.
- R5: Mode code 10 (alternate) gives oe=0, out=0 and ie=1, and applies the pull field.
- R6: A pull field of 01 asserts pull-up only, 10 asserts pull-down only, and 00 or 11 asserts neither. Pull-up and pull-down are never both asserted.
- R7: A write to address 6 sets each output data bit whose set bit (wdata[15:0]) is 1 and clears each bit whose clear bit (wdata[31:16]) is 1. Bits written as 0 leave their output bit unchanged. When both bits for a pin are 1, the output bit ends as 1.
- R8: Register map: 0 holds mode (2 bits per pin), 1 holds pull (2 bits per pin), 2 holds output type (bit per pin), 3 holds the low drive code bits (2 bits per pin) and 4 holds the high drive code bit (bit per pin). Address 5 is output data, 6 is set/clear and 7 is input. Configuration registers read back exactly what was written, with unused upper bits reading 0. Address 6 always reads 0.
- R9: Drive code {high bit, low bits} maps to strength class 2'b01 (large) for code 001, 2'b10 (maximum) for any code 1xx, and 2'b00 (normal) for all other codes.
- R10: After reset, mode, pull, output type, drive and output data are all zero, except two fields. Pin 13 has mode 10 with pull 01, and pin 14 has mode 10 with pull 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| pad_in | input | 16 | Pad input levels |
| pad_oe | output | 16 | Per-pin output driver enable |
| pad_out | output | 16 | Per-pin driven value |
| pad_pu | output | 16 | Per-pin pull-up request |
| pad_pd | output | 16 | Per-pin pull-down request |
| pad_ie | output | 16 | Per-pin digital input-buffer enable |
| pad_strength | output | 32 | Per-pin 2-bit drive strength class |

## Verification
The bound checker watches several things on every cycle: the pad decode of each pin against its stored mode, output type and output data (push-pull, open-drain and analog shut-off), the exclusiveness of pull-up and pull-down, the zero masking of disabled inputs, and the outcome of each set/clear write, including set winning over clear. Other behaviour shows only in the bench's scenarios. These include the two-edge synchronizer latency, the reset values of the debug pins, the register readback with zero upper bits, the set/clear register reading as zero, and the strength decode across the drive codes.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

   typedef enum logic [1:0] {
      PM_IN  = 2'b00,
      PM_OUT = 2'b01,
      PM_ALT = 2'b10,
      PM_ANA = 2'b11
   } pin_mode_e;

   typedef enum logic [1:0] {
      STR_NORM  = 2'b00,
      STR_LARGE = 2'b01,
      STR_MAX   = 2'b10
   } drv_class_e;

   localparam int unsigned RA_MODE  = 0;
   localparam int unsigned RA_PULL  = 1;
   localparam int unsigned RA_OTYPE = 2;
   localparam int unsigned RA_DRVLO = 3;
   localparam int unsigned RA_DRVHI = 4;
   localparam int unsigned RA_ODATA = 5;
   localparam int unsigned RA_SETCL = 6;
   localparam int unsigned RA_IDATA = 7;

   typedef struct packed {
      logic oe;
      logic out;
      logic pu;
      logic pd;
      logic ie;
   } pad_ctl_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_cfg_pkg::*;
#(
   parameter int unsigned DRV_W = 3
) (
   input  logic [1:0]       mode,
   input  logic [1:0]       pull,
   input  logic             otype,
   input  logic             odata,
   input  logic [DRV_W-1:0] drv,
   output pad_ctl_t         ctl,
   output logic [1:0]       str
);

   generate
      if (DRV_W != 3) begin : g_bad
         $error("gpio_pin_cell: DRV_W must be 3");
      end
   endgenerate

   logic pull_up_req, pull_dn_req;

   always_comb begin
      pull_up_req = (pull == 2'b01);
      pull_dn_req = (pull == 2'b10);
   end

   always_comb begin
      ctl = '0;
      unique case (pin_mode_e'(mode))
         PM_IN: begin
            ctl.ie = 1'b1;
            ctl.pu = pull_up_req;
            ctl.pd = pull_dn_req;
         end
         PM_OUT: begin
            ctl.ie = 1'b1;
            ctl.pu = pull_up_req;
            ctl.pd = pull_dn_req;
            if (otype) begin
               ctl.oe  = ~odata;
               ctl.out = 1'b0;
            end else begin
               ctl.oe  = 1'b1;
               ctl.out = odata;
            end
         end
         PM_ALT: begin
            ctl.ie = 1'b1;
            ctl.pu = pull_up_req;
            ctl.pd = pull_dn_req;
         end
         PM_ANA: ctl = '0;
         default: ctl = '0;
      endcase
   end

   always_comb begin
      if (drv[DRV_W-1])          str = STR_MAX;
      else if (drv == 3'b001)    str = STR_LARGE;
      else                       str = STR_NORM;
   end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_cfg_pkg::*;
#(
   parameter int unsigned NPINS  = 16,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DBG_A  = 13,
   parameter int unsigned DBG_B  = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic [NPINS-1:0]    idata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [2*NPINS-1:0]  mode_q,
   output logic [2*NPINS-1:0]  pull_q,
   output logic [NPINS-1:0]    otype_q,
   output logic [2*NPINS-1:0]  drvlo_q,
   output logic [NPINS-1:0]    drvhi_q,
   output logic [NPINS-1:0]    odr_q
);

   localparam int unsigned FW = 2 * NPINS;

   function automatic logic [FW-1:0] mode_init();
      logic [FW-1:0] r;
      r = '0;
      r[2*DBG_A +: 2] = PM_ALT;
      r[2*DBG_B +: 2] = PM_ALT;
      return r;
   endfunction

   function automatic logic [FW-1:0] pull_init();
      logic [FW-1:0] r;
      r = '0;
      r[2*DBG_A +: 2] = 2'b01;
      r[2*DBG_B +: 2] = 2'b10;
      return r;
   endfunction

   localparam logic [FW-1:0] MODE_RST = mode_init();
   localparam logic [FW-1:0] PULL_RST = pull_init();

   logic sel_mode, sel_pull, sel_otype, sel_drvlo, sel_drvhi, sel_odata, sel_setcl;
   logic [NPINS-1:0] set_v, clr_v;

   always_comb begin
      sel_mode  = bus_wr && (bus_addr == ADDR_W'(RA_MODE));
      sel_pull  = bus_wr && (bus_addr == ADDR_W'(RA_PULL));
      sel_otype = bus_wr && (bus_addr == ADDR_W'(RA_OTYPE));
      sel_drvlo = bus_wr && (bus_addr == ADDR_W'(RA_DRVLO));
      sel_drvhi = bus_wr && (bus_addr == ADDR_W'(RA_DRVHI));
      sel_odata = bus_wr && (bus_addr == ADDR_W'(RA_ODATA));
      sel_setcl = bus_wr && (bus_addr == ADDR_W'(RA_SETCL));
      set_v     = bus_wdata[NPINS-1:0];
      clr_v     = bus_wdata[FW-1:NPINS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_RST;
         pull_q  <= PULL_RST;
         otype_q <= '0;
         drvlo_q <= '0;
         drvhi_q <= '0;
         odr_q   <= '0;
      end else begin
         if (sel_mode)  mode_q  <= bus_wdata[FW-1:0];
         if (sel_pull)  pull_q  <= bus_wdata[FW-1:0];
         if (sel_otype) otype_q <= bus_wdata[NPINS-1:0];
         if (sel_drvlo) drvlo_q <= bus_wdata[FW-1:0];
         if (sel_drvhi) drvhi_q <= bus_wdata[NPINS-1:0];
         if (sel_odata)      odr_q <= bus_wdata[NPINS-1:0];
         else if (sel_setcl) odr_q <= (odr_q & ~clr_v) | set_v;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(RA_MODE):  bus_rdata[FW-1:0]    = mode_q;
         ADDR_W'(RA_PULL):  bus_rdata[FW-1:0]    = pull_q;
         ADDR_W'(RA_OTYPE): bus_rdata[NPINS-1:0] = otype_q;
         ADDR_W'(RA_DRVLO): bus_rdata[FW-1:0]    = drvlo_q;
         ADDR_W'(RA_DRVHI): bus_rdata[NPINS-1:0] = drvhi_q;
         ADDR_W'(RA_ODATA): bus_rdata[NPINS-1:0] = odr_q;
         ADDR_W'(RA_IDATA): bus_rdata[NPINS-1:0] = idata;
         default:           bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_cfg_pkg::*;
#(
   parameter int unsigned NPINS       = 16,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DBG_A       = 13,
   parameter int unsigned DBG_B       = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NPINS-1:0]     pad_in,
   output logic [NPINS-1:0]     pad_oe,
   output logic [NPINS-1:0]     pad_out,
   output logic [NPINS-1:0]     pad_pu,
   output logic [NPINS-1:0]     pad_pd,
   output logic [NPINS-1:0]     pad_ie,
   output logic [2*NPINS-1:0]   pad_strength
);

   localparam int unsigned DRV_W = 3;

   generate
      if (NPINS < 1 || DATA_W < 2 * NPINS) begin : g_bad_width
         $error("gpio_port_ctrl: DATA_W must hold two bits per pin");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("gpio_port_ctrl: ADDR_W must be at least 3");
      end
      if (DBG_A >= NPINS || DBG_B >= NPINS || DBG_A == DBG_B) begin : g_bad_dbg
         $error("gpio_port_ctrl: debug pin indices out of range");
      end
   endgenerate

   logic [2*NPINS-1:0] mode_q, pull_q, drvlo_q;
   logic [NPINS-1:0]   otype_q, drvhi_q, odr_q;
   logic [NPINS-1:0]   sync_q, idr_v;

   gpio_cfg_regs #(
      .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .DBG_A(DBG_A), .DBG_B(DBG_B)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .idata(idr_v), .bus_rdata(bus_rdata),
      .mode_q(mode_q), .pull_q(pull_q), .otype_q(otype_q),
      .drvlo_q(drvlo_q), .drvhi_q(drvhi_q), .odr_q(odr_q)
   );

   gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
   );

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         pad_ctl_t ctl;
         gpio_pin_cell #(.DRV_W(DRV_W)) u_cell (
            .mode(mode_q[2*p +: 2]),
            .pull(pull_q[2*p +: 2]),
            .otype(otype_q[p]),
            .odata(odr_q[p]),
            .drv({drvhi_q[p], drvlo_q[2*p +: 2]}),
            .ctl(ctl),
            .str(pad_strength[2*p +: 2])
         );
         assign pad_oe[p]  = ctl.oe;
         assign pad_out[p] = ctl.out;
         assign pad_pu[p]  = ctl.pu;
         assign pad_pd[p]  = ctl.pd;
         assign pad_ie[p]  = ctl.ie;
      end
   endgenerate

   assign idr_v = sync_q & pad_ie;

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
   parameter int unsigned NPINS  = 16,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [2*NPINS-1:0]  mode_q,
   input logic [NPINS-1:0]    otype_q,
   input logic [NPINS-1:0]    odr_q,
   input logic [NPINS-1:0]    idr_v,
   input logic [NPINS-1:0]    pad_oe,
   input logic [NPINS-1:0]    pad_out,
   input logic [NPINS-1:0]    pad_pu,
   input logic [NPINS-1:0]    pad_pd,
   input logic [NPINS-1:0]    pad_ie
);

   localparam logic [ADDR_W-1:0] SETCL_ADDR = ADDR_W'(6);

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_chk
         // R2
         push_pull_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*p +: 2] == 2'b01 && !otype_q[p])
               |-> (pad_oe[p] && pad_out[p] == odr_q[p] && pad_ie[p]));

         // R3
         open_drain_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*p +: 2] == 2'b01 && otype_q[p])
               |-> (!pad_out[p] && pad_oe[p] == !odr_q[p] && pad_ie[p]));

         // R4
         analog_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*p +: 2] == 2'b11)
               |-> (!pad_oe[p] && !pad_ie[p] && !pad_pu[p] && !pad_pd[p]));

         // R4
         input_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pad_ie[p] |-> !idr_v[p]);

         // R6
         pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(pad_pu[p] && pad_pd[p]));

         // R7
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == SETCL_ADDR && bus_wdata[p]) |=> odr_q[p]);

         // R7
         clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == SETCL_ADDR && bus_wdata[NPINS+p] && !bus_wdata[p])
               |=> !odr_q[p]);

         // R7
         zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == SETCL_ADDR && !bus_wdata[NPINS+p] && !bus_wdata[p])
               |=> $stable(odr_q[p]));
      end
   endgenerate

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
   .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
   .mode_q(mode_q), .otype_q(otype_q), .odr_q(odr_q), .idr_v(idr_v),
   .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
   .pad_pd(pad_pd), .pad_ie(pad_ie)
);

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_oe, pad_out, pad_pu, pad_pd, pad_ie;
   logic [31:0] pad_strength;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #4 clk = ~clk;

   gpio_port_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
      .pad_pd(pad_pd), .pad_ie(pad_ie), .pad_strength(pad_strength)
   );

   // stimulus: [17:16] mode [15:14] pull [13] otype [12:10] drive [9] odata [8] pad
   // expected: [7] oe [6] out [5] pu [4] pd [3] ie [2:1] strength [0] input bit
   localparam int NV = 10;
   localparam logic [17:0] VEC [NV] = '{
      {2'b00, 2'b00, 1'b0, 3'b000, 1'b0, 1'b1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1},
      {2'b00, 2'b01, 1'b0, 3'b001, 1'b1, 1'b0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0},
      {2'b01, 2'b00, 1'b0, 3'b000, 1'b1, 1'b1,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1},
      {2'b01, 2'b10, 1'b0, 3'b100, 1'b0, 1'b0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0},
      {2'b01, 2'b01, 1'b1, 3'b010, 1'b0, 1'b0,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0},
      {2'b01, 2'b01, 1'b1, 3'b011, 1'b1, 1'b1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1},
      {2'b11, 2'b01, 1'b0, 3'b111, 1'b1, 1'b1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0},
      {2'b11, 2'b10, 1'b1, 3'b000, 1'b0, 1'b1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0},
      {2'b10, 2'b10, 1'b0, 3'b101, 1'b1, 1'b1,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b1},
      {2'b00, 2'b11, 1'b0, 3'b001, 1'b0, 1'b1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      rd(3'd0, r); check("R10 mode after reset", r, 32'h2800_0000);
      rd(3'd1, r); check("R10 pull after reset", r, 32'h2400_0000);
      rd(3'd5, r); check("R10 output data after reset", r, 32'h0);
      check("R10 pad pull-up after reset", {16'h0, pad_pu}, 32'h0000_2000);
      check("R10 pad pull-down after reset", {16'h0, pad_pd}, 32'h0000_4000);
      check("R10 pad oe after reset", {16'h0, pad_oe}, 32'h0);
      check("R10 pad ie after reset", {16'h0, pad_ie}, 32'h0000_FFFF);

      // vector table on pin 3
      for (int i = 0; i < NV; i++) begin
         logic [17:0] v;
         string mtag;
         v = VEC[i];
         wr(3'd0, 32'(v[17:16]) << 6);
         wr(3'd1, 32'(v[15:14]) << 6);
         wr(3'd2, 32'(v[13]) << 3);
         wr(3'd3, 32'(v[11:10]) << 6);
         wr(3'd4, 32'(v[12]) << 3);
         wr(3'd5, 32'(v[9]) << 3);
         pad_in = 16'(v[8]) << 3;
         repeat (3) @(negedge clk);
         case (v[17:16])
            2'b00: mtag = "R1";
            2'b01: mtag = v[13] ? "R3" : "R2";
            2'b10: mtag = "R5";
            default: mtag = "R4";
         endcase
         bus_addr = 3'd7;
         #1;
         check($sformatf("%s vector %0d oe/out/ie/in", mtag, i),
               {28'h0, pad_oe[3], pad_out[3], pad_ie[3], bus_rdata[3]},
               {28'h0, v[7], v[6], v[3], v[0]});
         check($sformatf("R6 vector %0d pulls", i),
               {30'h0, pad_pu[3], pad_pd[3]}, {30'h0, v[5], v[4]});
         check($sformatf("R9 vector %0d strength", i),
               {30'h0, pad_strength[7:6]}, {30'h0, v[2:1]});
      end

      // R1 synchronizer latency on pin 0 (input mode)
      wr(3'd0, 32'h0);
      pad_in = 16'h0000;
      repeat (3) @(negedge clk);
      pad_in = 16'h0001;
      bus_addr = 3'd7;
      @(negedge clk); #1;
      check("R1 input bit after one edge", {31'h0, bus_rdata[0]}, 32'h0);
      @(negedge clk); #1;
      check("R1 input bit after two edges", {31'h0, bus_rdata[0]}, 32'h1);

      // R7 set/clear
      wr(3'd5, 32'h0000_00F0);
      wr(3'd6, 32'h00FF_0F01);
      rd(3'd5, r); check("R7 set wins and clears applied", r, 32'h0000_0F01);
      wr(3'd6, 32'h0000_0000);
      rd(3'd5, r); check("R7 zero write leaves data", r, 32'h0000_0F01);
      wr(3'd6, 32'h0F00_0000);
      rd(3'd5, r); check("R7 clear only", r, 32'h0000_0001);

      // R8 readback
      rd(3'd6, r); check("R8 set/clear reads zero", r, 32'h0);
      wr(3'd1, 32'hDEAD_BEEF);
      rd(3'd1, r); check("R8 pull readback", r, 32'hDEAD_BEEF);
      wr(3'd2, 32'hFFFF_1234);
      rd(3'd2, r); check("R8 output type readback upper zero", r, 32'h0000_1234);
      wr(3'd4, 32'hABCD_8421);
      rd(3'd4, r); check("R8 drive high readback upper zero", r, 32'h0000_8421);
      wr(3'd3, 32'h1357_9BDF);
      rd(3'd3, r); check("R8 drive low readback", r, 32'h1357_9BDF);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule